// File: doc/BRIEF.md
# Single-Wire Register Bus Host

This block is the host end of a single-wire, open-drain serial bus that carries 8-bit register reads and writes to one peripheral. A request comes in over a small parallel interface: a 7-bit register address, a direction flag, write data and a one-cycle start strobe. The host can first hold the line low as a break. It then sends a command byte. Depending on the direction, it either sends a data byte or releases the line and captures the byte the peripheral returns.

Each bit is a return-to-one frame timed from the falling edge that opens it. The host always pulls the line low for a short start phase. For a 0 it keeps the line low until a later stop point. The line then stays released until the bit period is over. Received bits are taken a fixed delay after each falling edge seen on the synchronised line. If the peripheral stays silent, the host ends the transaction with a timeout flag and makes the next request begin with a break. All timings are parameters counted in clock cycles. The output is an active-low pull-down enable and never drives the line high.

Top module: `swb_host`

## Requirements
- R1: The command byte holds the register address in bits 6:0 and the direction in bit 7 (1 = write, 0 = read). Every byte on the wire goes least-significant bit first, so a read of address 0x73 sends 1,1,0,0,1,1,1,0.
- R2: A transmitted 1 holds the line low for START_CYC cycles and a transmitted 0 for STOP_CYC cycles, both counted from the frame's falling edge. Consecutive frames start CYCLE_CYC cycles apart.
- R3: A write sends the command byte followed by the data byte, as 16 frames in a row, then pulses done_o. A start_i seen while idle makes busy_o high on the next cycle.
- R4: A read sends only the 8 command frames and then releases the line. Each returned bit is sampled SMP_CYC cycles after its synchronised falling edge and assembled LSB first, so the wire sequence 1,0,1,0,0,1,1,0 yields rdata_o = 0x65.
- R5: A break (line low for BRK_CYC cycles, then released for REC_CYC cycles before the first command frame) comes before the command on the first request after reset, on the first request after a timeout, and on any request made with brk_i high. The line is never held low for more than BRK_CYC cycles in a row.
- R6: On any other request, no break is sent.
- R7: During a read, if no falling edge arrives within TO_CYC cycles of entering the wait for a bit, the host ends the transaction with done_o and timeout_o both high and leaves rdata_o unchanged. timeout_o stays high until the next accepted start.
- R8: start_i is ignored while busy_o is high. No second transaction is sent and the request's fields have no effect.
- R9: During and right after reset, line_drv_no is 1 and busy_o, done_o and timeout_o are 0.
- R10: Whenever the host is idle, the line is released (line_drv_no = 1).
- R11: done_o is a single-cycle pulse. rdata_o changes only on the cycle done_o is high after a successful read, so it keeps its value through writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe, taken only when idle |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| addr_i | input | 7 | Register address |
| wdata_i | input | 8 | Data for a write |
| brk_i | input | 1 | Force a break before this request's command |
| line_i | input | 1 | Sensed level of the bus line (asynchronous) |
| line_drv_no | output | 1 | 0 pulls the line low, 1 releases it |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 8 | Last byte read |
| timeout_o | output | 1 | Last transaction ended with no response |

## Verification
The assertions assume that start_i is only meaningful while idle and that the line sensed on line_i is the wired-AND of the host's own pull-down and a peripheral that never pulls longer than the break time. The bench's peripheral model keeps to this. It answers only after the host's last command frame has finished, it uses frame timings that place each bit's valid window around the host's sample point, and it never drives while the host transmits. Random requests are issued one at a time after the previous response has fully ended, so every sensed edge belongs to a single frame.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_REC,
    ST_TX,
    ST_RX,
    ST_DONE
  } swb_state_e;

  // bit 7 = direction, 6:0 = register
  function automatic logic [BYTE_W-1:0] make_cmd(input logic wr, input logic [ADDR_W-1:0] addr);
    return {wr, addr};
  endfunction
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/swb_tx_frame.sv
module swb_tx_frame #(
  parameter int unsigned START_CYC = 50,
  parameter int unsigned STOP_CYC  = 145,
  parameter int unsigned CYCLE_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic bit_i,
  output logic low_o,
  output logic end_o
);
  localparam int unsigned CW = $clog2(CYCLE_CYC);
  localparam logic [CW-1:0] START_C = CW'(START_CYC);
  localparam logic [CW-1:0] STOP_C  = CW'(STOP_CYC);
  localparam logic [CW-1:0] LAST_C  = CW'(CYCLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || end_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign end_o = run_i && (cnt_q == LAST_C);
  // start phase always low; a zero stays low up to the stop point
  assign low_o = run_i && ((cnt_q < START_C) || (!bit_i && (cnt_q < STOP_C)));
endmodule

// File: rtl/swb_rx_frame.sv
module swb_rx_frame #(
  parameter int unsigned SMP_CYC = 120,
  parameter int unsigned TO_CYC  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fall_i,
  output logic smp_o,
  output logic to_o
);
  localparam int unsigned MAXC = (TO_CYC > SMP_CYC) ? TO_CYC : SMP_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SMP_C = CW'(SMP_CYC - 1);
  localparam logic [CW-1:0] TO_C  = CW'(TO_CYC - 1);

  logic          wait_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b1;
      cnt_q  <= '0;
    end else if (!run_i) begin
      wait_q <= 1'b1;
      cnt_q  <= '0;
    end else if (wait_q) begin
      if (fall_i) begin
        wait_q <= 1'b0;
        cnt_q  <= '0;
      end else if (to_o) begin
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end else if (smp_o) begin
      wait_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign to_o  = run_i && wait_q && !fall_i && (cnt_q == TO_C);
  assign smp_o = run_i && !wait_q && (cnt_q == SMP_C);
endmodule

// File: rtl/swb_host.sv
module swb_host
  import swb_pkg::*;
#(
  parameter int unsigned BRK_CYC     = 190,
  parameter int unsigned REC_CYC     = 40,
  parameter int unsigned START_CYC   = 50,
  parameter int unsigned STOP_CYC    = 145,
  parameter int unsigned CYCLE_CYC   = 200,
  parameter int unsigned SMP_CYC     = 120,
  parameter int unsigned TO_CYC      = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              brk_i,
  input  logic              line_i,
  output logic              line_drv_no,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              timeout_o
);
  localparam int unsigned MAXB = (BRK_CYC > REC_CYC) ? BRK_CYC : REC_CYC;
  localparam int unsigned BW   = $clog2(MAXB);
  localparam logic [BW-1:0] BRK_C = BW'(BRK_CYC - 1);
  localparam logic [BW-1:0] REC_C = BW'(REC_CYC - 1);
  localparam int unsigned NW   = $clog2(2 * BYTE_W);
  localparam logic [NW-1:0] LAST_WR = NW'(2 * BYTE_W - 1);
  localparam logic [NW-1:0] LAST_RD = NW'(BYTE_W - 1);

  swb_state_e              st_q;
  logic [BW-1:0]           tmr_q;
  logic [2*BYTE_W-1:0]     tx_sh_q;
  logic [BYTE_W-2:0]       rx_sh_q;
  logic [NW-1:0]           bit_cnt_q;
  logic                    wr_q;
  logic                    need_brk_q;
  logic                    to_q;
  logic [BYTE_W-1:0]       rdata_q;

  logic line_s, fall_s;
  logic tx_low, tx_end;
  logic rx_smp, rx_to;

  swb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  swb_tx_frame #(
    .START_CYC (START_CYC),
    .STOP_CYC  (STOP_CYC),
    .CYCLE_CYC (CYCLE_CYC)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q == ST_TX),
    .bit_i  (tx_sh_q[0]),
    .low_o  (tx_low),
    .end_o  (tx_end)
  );

  swb_rx_frame #(
    .SMP_CYC (SMP_CYC),
    .TO_CYC  (TO_CYC)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q == ST_RX),
    .fall_i (fall_s),
    .smp_o  (rx_smp),
    .to_o   (rx_to)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      tmr_q      <= '0;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      bit_cnt_q  <= '0;
      wr_q       <= 1'b0;
      need_brk_q <= 1'b1;
      to_q       <= 1'b0;
      rdata_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            tx_sh_q   <= {wdata_i, make_cmd(wr_i, addr_i)};
            wr_q      <= wr_i;
            bit_cnt_q <= '0;
            tmr_q     <= '0;
            to_q      <= 1'b0;
            st_q      <= (need_brk_q || brk_i) ? ST_BRK : ST_TX;
          end
        end
        ST_BRK: begin
          if (tmr_q == BRK_C) begin
            tmr_q      <= '0;
            need_brk_q <= 1'b0;
            st_q       <= ST_REC;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_REC: begin
          if (tmr_q == REC_C) begin
            tmr_q <= '0;
            st_q  <= ST_TX;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_TX: begin
          if (tx_end) begin
            tx_sh_q <= tx_sh_q >> 1;
            if (bit_cnt_q == (wr_q ? LAST_WR : LAST_RD)) begin
              bit_cnt_q <= '0;
              st_q      <= wr_q ? ST_DONE : ST_RX;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        ST_RX: begin
          if (rx_to) begin
            to_q       <= 1'b1;
            need_brk_q <= 1'b1;
            st_q       <= ST_DONE;
          end else if (rx_smp) begin
            rx_sh_q <= {line_s, rx_sh_q[BYTE_W-2:1]};
            if (bit_cnt_q == LAST_RD) begin
              rdata_q <= {line_s, rx_sh_q};
              st_q    <= ST_DONE;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign line_drv_no = !((st_q == ST_BRK) || tx_low);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign rdata_o     = rdata_q;
  assign timeout_o   = to_q;
endmodule

// File: rtl/swb_host_chk.sv
module swb_host_chk #(
  parameter int unsigned BRK_CYC = 190
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       line_drv_no,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] rdata_o,
  input logic       timeout_o
);
  localparam int unsigned LW = $clog2(BRK_CYC + 2);

  logic [LW-1:0] lo_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           lo_run_q <= '0;
    else if (!line_drv_no) begin
      if (lo_run_q != '1)  lo_run_q <= lo_run_q + 1'b1;
    end else               lo_run_q <= '0;
  end

  // R10
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> line_drv_no);

  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));

  // R7
  timeout_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);

  // R3
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R5
  low_run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_run_q <= LW'(BRK_CYC));
endmodule

bind swb_host swb_host_chk #(.BRK_CYC(BRK_CYC)) u_swb_host_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .line_drv_no (line_drv_no),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .timeout_o   (timeout_o)
);

// File: tb/sim_swb_host.sv
module sim_swb_host;
  localparam int CLK_PERIOD = 10;
  localparam int BRK = 38, REC = 8, STA = 10, STO = 29, CYC = 40, SMP = 24, TO = 200;
  localparam int RSP = 40;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start = 1'b0, wr = 1'b0, brk = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       drv_n, busy, done, timeout, line;
  logic [7:0] rdata;
  logic       p_drv_n = 1'b1;

  assign line = drv_n & p_drv_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  swb_host #(
    .BRK_CYC(BRK), .REC_CYC(REC), .START_CYC(STA), .STOP_CYC(STO),
    .CYCLE_CYC(CYC), .SMP_CYC(SMP), .TO_CYC(TO), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .brk_i(brk), .line_i(line), .line_drv_no(drv_n),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .timeout_o(timeout)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  function automatic int exp_lo(input logic b);
    return b ? STA : STO;
  endfunction

  // peripheral model
  logic [7:0] regs [128];
  logic [7:0] exp_mem [128];
  bit   mute = 0, p_tx = 0, resp_go = 0, phase = 0;
  logic [7:0] resp_val = '0, psh = '0, pcmd = '0, last_cmd = '0;
  int   brk_cnt = 0, cmd_cnt = 0, wr_cnt = 0, pcnt = 0;
  int   lo_len = 0, hi_len = 0, hi_gap = 0, n_log = 0;
  int   lo_log [40];
  int   hi_log [40];

  always @(negedge clk) begin
    if (rst_n && !p_tx) begin
      if (!line) begin
        if (lo_len == 0) hi_gap = hi_len;
        lo_len++;
        hi_len = 0;
      end else begin
        if (lo_len > 0) begin
          if (n_log < 40) begin
            lo_log[n_log] = lo_len;
            hi_log[n_log] = hi_gap;
            n_log++;
          end
          if (lo_len >= 34) begin
            brk_cnt++;
            pcnt = 0;
            phase = 0;
          end else begin
            psh = {1'(lo_len < 20), psh[7:1]};
            pcnt++;
            if (pcnt == 8) begin
              pcnt = 0;
              if (!phase) begin
                pcmd = psh;
                last_cmd = psh;
                cmd_cnt++;
                if (psh[7]) phase = 1;
                else if (!mute) begin
                  resp_val = regs[psh[6:0]];
                  resp_go = 1;
                end
              end else begin
                regs[pcmd[6:0]] = psh;
                wr_cnt++;
                phase = 0;
              end
            end
          end
          lo_len = 0;
        end
        hi_len++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (resp_go) begin
      resp_go = 0;
      p_tx = 1;
      repeat (RSP - 1) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        p_drv_n = 1'b0;
        repeat (STA) @(negedge clk);
        p_drv_n = resp_val[i];
        repeat (STO - STA) @(negedge clk);
        p_drv_n = 1'b1;
        repeat (CYC - STO) @(negedge clk);
      end
      p_tx = 0;
      hi_len = 0;
    end
  end

  logic got_to;
  logic [7:0] got_rd;

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) chk(req, "done never came", 0, 1);
    got_to = timeout;
    got_rd = rdata;
    @(negedge clk);
    chk("R11", "done width", int'(done), 0);
  endtask

  task automatic settle();
    repeat (2 * CYC) @(negedge clk);
    while (p_tx) @(negedge clk);
    repeat (CYC) @(negedge clk);
  endtask

  task automatic do_txn(input logic w, input logic [6:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    wr = w; addr = a; wdata = d; brk = b; start = 1'b1;
    n_log = 0;
    @(negedge clk);
    start = 1'b0; brk = 1'b0;
    wait_done("R3");
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bc;
    logic [15:0] word;
    logic [7:0] prev_rd;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 128; i++) begin
      regs[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "drv_n in reset", int'(drv_n), 1);
    chk("R9", "busy in reset", int'(busy), 0);
    chk("R9", "done in reset", int'(done), 0);
    chk("R9", "timeout in reset", int'(timeout), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9", "drv_n after reset", int'(drv_n), 1);
    chk("R10", "idle busy", int'(busy), 0);

    // first access: write 0x11 <= 0xA5, break forced (R5)
    bc = brk_cnt;
    do_txn(1'b1, 7'h11, 8'hA5, 1'b0);
    chk("R5", "first access break", brk_cnt - bc, 1);
    chk("R5", "break low length", lo_log[0], BRK);
    chk("R5", "break recovery", hi_log[1], REC);
    chk("R1", "write command byte", int'(last_cmd), 8'h91);
    chk("R3", "peripheral reg 0x11", int'(regs[7'h11]), 8'hA5);
    chk("R3", "frames in write", n_log, 17);
    exp_mem[7'h11] = 8'hA5;
    word = {8'hA5, 8'h91};
    for (int k = 1; k <= 16; k++) begin
      chk("R2", $sformatf("low of frame %0d", k), lo_log[k], exp_lo(word[k-1]));
      if (k >= 2) chk("R2", $sformatf("period of frame %0d", k), hi_log[k] + lo_log[k-1], CYC);
    end
    chk("R11", "rdata kept after write", int'(got_rd), 0);
    chk("R7", "no timeout on write", int'(got_to), 0);

    // read of 0x73 returning 0x65, no break (R4, R6, R1)
    regs[7'h73] = 8'h65;
    exp_mem[7'h73] = 8'h65;
    bc = brk_cnt;
    do_txn(1'b0, 7'h73, 8'h00, 1'b0);
    chk("R6", "no break", brk_cnt - bc, 0);
    chk("R1", "read command byte", int'(last_cmd), 8'h73);
    chk("R4", "host frames in read", n_log, 8);
    for (int k = 0; k < 8; k++)
      chk("R1", $sformatf("cmd bit %0d on wire", k), lo_log[k], exp_lo(8'h73 >> k));
    chk("R4", "read data", int'(got_rd), 8'h65);

    // requested break (R5)
    bc = brk_cnt;
    do_txn(1'b0, 7'h11, 8'h00, 1'b1);
    chk("R5", "requested break", brk_cnt - bc, 1);
    chk("R4", "read after break", int'(got_rd), 8'hA5);

    // timeout (R7)
    prev_rd = rdata;
    mute = 1;
    do_txn(1'b0, 7'h05, 8'h00, 1'b0);
    mute = 0;
    chk("R7", "timeout flag", int'(got_to), 1);
    chk("R7", "rdata unchanged on timeout", int'(got_rd), int'(prev_rd));
    chk("R7", "timeout held", int'(timeout), 1);
    chk("R10", "released after timeout", int'(drv_n), 1);
    bc = brk_cnt;
    do_txn(1'b0, 7'h05, 8'h00, 1'b0);
    chk("R5", "break after timeout", brk_cnt - bc, 1);
    chk("R7", "timeout cleared", int'(got_to), 0);
    chk("R4", "read after timeout", int'(got_rd), int'(exp_mem[5]));

    // start while busy (R8)
    begin
      int cc, wc, dn;
      cc = cmd_cnt; wc = wr_cnt; dn = 0;
      @(negedge clk);
      wr = 1'b1; addr = 7'h22; wdata = 8'h3C; start = 1'b1; n_log = 0;
      @(negedge clk);
      start = 1'b0;
      repeat (100) @(negedge clk);
      wr = 1'b1; addr = 7'h23; wdata = 8'hFF; brk = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0; brk = 1'b0;
      for (int t = 0; t < 2000; t++) begin
        if (done) dn++;
        @(negedge clk);
      end
      settle();
      exp_mem[7'h22] = 8'h3C;
      chk("R8", "single done", dn, 1);
      chk("R8", "single command", cmd_cnt - cc, 1);
      chk("R8", "single write", wr_cnt - wc, 1);
      chk("R8", "reg 0x23 untouched", int'(regs[7'h23]), int'(exp_mem[7'h23]));
      chk("R8", "reg 0x22 written", int'(regs[7'h22]), 8'h3C);
    end

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic w, b;
      logic [6:0] a;
      logic [7:0] d;
      w = 1'($urandom);
      b = (($urandom % 5) == 0);
      a = 7'($urandom);
      d = 8'($urandom);
      prev_rd = rdata;
      bc = brk_cnt;
      do_txn(w, a, d, b);
      chk("R5", "random break count", brk_cnt - bc, int'(b));
      chk("R1", "random command", int'(last_cmd), int'({w, a}));
      if (w) begin
        exp_mem[a] = d;
        chk("R3", "random write", int'(regs[a]), int'(d));
        chk("R11", "rdata held on write", int'(got_rd), int'(prev_rd));
      end else begin
        chk("R4", "random read", int'(got_rd), int'(exp_mem[a]));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule